// File: doc/BRIEF.md
# Dual-Channel DAC Data and Trigger Controller

This block is the digital register side of a two-channel digital-to-analog converter. Software, or a DMA engine, writes sample data into a holding register per channel. Several write addresses lead to that register, one per data format, and a set of dual addresses fills both channels with one bus write. A second register per channel, the output register, drives the converter. The block decides when the holding value moves into the output register.

Each channel runs in one of two ways. In direct mode the move follows every holding write. In triggered mode the move waits for the channel's selected event: a timer pulse, a rising edge on the external line, or a software trigger bit. In triggered mode a channel can also request its next sample over DMA. It raises an underrun flag when a trigger finds that no fresh sample has arrived.

Top module: `dac_trig_ctrl`

## Requirements
- R1: After reset both output registers read 0, the DMA request lines are low, and the control, software-trigger and status registers read 0.
- R2: The single-channel holding addresses are 0x10/0x14/0x18 for channel 1 and 0x20/0x24/0x28 for channel 2. The three formats are: 12-bit right-aligned, data bits [11:0]; 12-bit left-aligned, bits [15:4]; and 8-bit right-aligned, bits [7:0], placed in the top 8 bits of the 12-bit output with the low 4 bits zero.
- R3: The dual addresses 0x30/0x34/0x38 use the same three formats and update both holding registers in one write. Channel 1 takes its field from the low half of the write data and channel 2 from the high half. For the 8-bit format channel 1 takes bits [7:0] and channel 2 takes bits [15:8].
- R4: With the channel enabled and its trigger enable clear, a holding write moves the new value to the output register on the second rising edge after the write is sampled, and not before.
- R5: With the trigger enable set, a holding write leaves the output unchanged. The selected trigger moves the holding value to the output on the edge after the one at which the trigger is sampled.
- R6: The trigger-select codes are: 0 to 5 for timer event lines 0 to 5, where each sampled high cycle is one event; 6 for a rising edge of the external line, so a held level or a falling edge does nothing; and 7 for the software trigger. An unselected source has no effect.
- R7: Writing 1 to bit c-1 of the software-trigger register (0x04) sets that channel's bit, and it reads back as 1. When the channel uses code 7, hardware clears the bit at the next edge, and the transfer follows one edge later.
- R8: The control register at 0x00 holds channel 1 in bits [5:0] and channel 2 in bits [21:16]. Each half has enable in bit 0, trigger enable in bit 1, trigger select in bits [4:2] and DMA enable in bit 5, and reads back as written.
- R9: A channel whose enable is 0 ignores both holding writes and triggers: its output register does not change.
- R10: With DMA enabled, an accepted trigger raises that channel's DMA request at the edge where the trigger is sampled. The next holding write to that channel lowers it.
- R11: A trigger that finds the DMA request still high, with no holding write in the same cycle, performs no transfer. It sets the channel's underrun flag, which is bit 0 for channel 1 and bit 1 for channel 2 of the status register at 0x08. Writing 1 clears the flag and writing 0 leaves it set.
- R12: The output registers read back at 0x40 (channel 1) and 0x44 (channel 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| tim_trig_i | input | 6 | Timer event pulses |
| ext_trig_i | input | 1 | External trigger line (synchronous) |
| dac1_data_o | output | 12 | Channel 1 output register |
| dac2_data_o | output | 12 | Channel 2 output register |
| dma_req_o | output | 2 | DMA request per channel |

## Verification
The assertions watch four properties on every cycle. A disabled channel never moves its output. A direct-mode write reaches the output exactly two edges later. A consumed software trigger bit is cleared. A starved trigger sets the underrun flag, holds the output and leaves the request handling consistent. Format packing and the dual-alias field split can only be shown by the bench's data sweeps, which go across all formats and both channels. The same holds for selection of each timer line, edge-only behaviour on the external line, and the write-one-to-clear status semantics.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int unsigned NCH     = 2;
  localparam int unsigned DW      = 12;
  localparam int unsigned AW      = 8;
  localparam int unsigned BW      = 32;
  localparam int unsigned NUM_TIM = 6;
  localparam int unsigned TSEL_W  = $clog2(NUM_TIM + 2);
  localparam int unsigned SEL_EXT = NUM_TIM;
  localparam int unsigned SEL_SW  = NUM_TIM + 1;

  typedef enum logic [1:0] {FMT_R12 = 2'd0, FMT_L12 = 2'd1, FMT_R8 = 2'd2} fmt_e;

  typedef struct packed {
    logic              dma_en;
    logic [TSEL_W-1:0] tsel;
    logic              trig_en;
    logic              en;
  } ch_cfg_t;

  localparam int unsigned CFG_W = $bits(ch_cfg_t);

  localparam logic [AW-1:0] A_CTRL   = 8'h00;
  localparam logic [AW-1:0] A_SWTRIG = 8'h04;
  localparam logic [AW-1:0] A_STATUS = 8'h08;
  localparam logic [AW-1:0] A_DOUT1  = 8'h40;
  localparam logic [AW-1:0] A_DOUT2  = 8'h44;
  localparam logic [3:0]    PG_CH1   = 4'h1;
  localparam logic [3:0]    PG_CH2   = 4'h2;
  localparam logic [3:0]    PG_DUAL  = 4'h3;

  function automatic logic [DW-1:0] unpack_fmt(input fmt_e f, input logic [15:0] d);
    case (f)
      FMT_L12: unpack_fmt = d[15:4];
      FMT_R8:  unpack_fmt = {d[7:0], 4'h0};
      default: unpack_fmt = d[11:0];
    endcase
  endfunction
endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
  import dac_pkg::*;
(
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [BW-1:0]           wdata_i,
  output logic [NCH-1:0]          hold_we_o,
  output logic [NCH-1:0][DW-1:0]  hold_d_o
);
  fmt_e fmt;
  logic fmt_ok;

  always_comb begin
    fmt         = fmt_e'(addr_i[3:2]);
    fmt_ok      = (addr_i[3:2] != 2'd3) && (addr_i[1:0] == 2'b00);
    hold_we_o   = '0;
    hold_d_o[0] = unpack_fmt(fmt, wdata_i[15:0]);
    hold_d_o[1] = unpack_fmt(fmt, wdata_i[15:0]);
    if (we_i && fmt_ok) begin
      case (addr_i[7:4])
        PG_CH1:  hold_we_o = 2'b01;
        PG_CH2:  hold_we_o = 2'b10;
        PG_DUAL: begin
          hold_we_o = 2'b11;
          // 8-bit dual packs channel 2 in the second byte
          hold_d_o[1] = (fmt == FMT_R8) ? unpack_fmt(fmt, {8'h00, wdata_i[15:8]})
                                        : unpack_fmt(fmt, wdata_i[31:16]);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dac_trig_sel.sv
module dac_trig_sel
  import dac_pkg::*;
(
  input  logic [TSEL_W-1:0]  tsel_i,
  input  logic [NUM_TIM-1:0] tim_i,
  input  logic               ext_rise_i,
  input  logic               sw_i,
  output logic               hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < NUM_TIM; i++)
      if (tsel_i == TSEL_W'(i)) hit_o = tim_i[i];
    if (tsel_i == TSEL_W'(SEL_EXT)) hit_o = ext_rise_i;
    if (tsel_i == TSEL_W'(SEL_SW))  hit_o = sw_i;
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dac_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ch_cfg_t            cfg_i,
  input  logic               hold_we_i,
  input  logic [DW-1:0]      hold_d_i,
  input  logic               sw_set_i,
  input  logic [NUM_TIM-1:0] tim_i,
  input  logic               ext_rise_i,
  input  logic               ur_clr_i,
  output logic [DW-1:0]      dout_o,
  output logic               sw_o,
  output logic               dma_req_o,
  output logic               underrun_o
);
  logic [DW-1:0] hold_q, dout_q;
  logic pend_q, sw_q, req_q, ur_q;
  logic sel_hit, trig_hit, is_sw, starve, xfer_go;

  dac_trig_sel u_sel (
    .tsel_i     (cfg_i.tsel),
    .tim_i      (tim_i),
    .ext_rise_i (ext_rise_i),
    .sw_i       (sw_q),
    .hit_o      (sel_hit)
  );

  assign is_sw    = (cfg_i.tsel == TSEL_W'(SEL_SW));
  assign trig_hit = cfg_i.en & cfg_i.trig_en & sel_hit;
  assign starve   = cfg_i.dma_en & req_q & ~hold_we_i;
  assign xfer_go  = cfg_i.en & (cfg_i.trig_en ? (trig_hit & ~starve) : hold_we_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      dout_q <= '0;
      pend_q <= 1'b0;
      sw_q   <= 1'b0;
      req_q  <= 1'b0;
      ur_q   <= 1'b0;
    end else begin
      if (hold_we_i) hold_q <= hold_d_i;
      pend_q <= xfer_go;
      if (pend_q) dout_q <= hold_q;
      sw_q <= (sw_q & ~(trig_hit & is_sw)) | sw_set_i;
      if (!cfg_i.dma_en)                req_q <= 1'b0;
      else if (trig_hit && !starve)     req_q <= 1'b1;
      else if (hold_we_i)               req_q <= 1'b0;
      if (trig_hit && starve)           ur_q <= 1'b1;
      else if (ur_clr_i)                ur_q <= 1'b0;
    end
  end

  assign dout_o     = dout_q;
  assign sw_o       = sw_q;
  assign dma_req_o  = req_q;
  assign underrun_o = ur_q;

  AST_DIRECT_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.en && !cfg_i.trig_en && hold_we_i |=> ##1 (dout_q == $past(hold_d_i, 2))); // R4
  AST_DISABLED_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> $stable(dout_q)); // R9
  AST_SW_AUTOCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_hit && is_sw && !sw_set_i |=> !sw_q); // R7
  AST_UNDERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_hit && cfg_i.dma_en && req_q && !hold_we_i |=> ur_q && req_q); // R11
  AST_STARVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_hit && cfg_i.dma_en && req_q && !hold_we_i && !pend_q |=> ##1 $stable(dout_q)); // R11
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_we_i && !trig_hit |=> !req_q); // R10
endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
  import dac_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic [5:0]  tim_trig_i,
  input  logic        ext_trig_i,
  output logic [11:0] dac1_data_o,
  output logic [11:0] dac2_data_o,
  output logic [1:0]  dma_req_o
);
  localparam int unsigned HALF = BW / 2;

  ch_cfg_t [NCH-1:0]         cfg_q;
  logic    [NCH-1:0]         hold_we, sw, ur, req;
  logic    [NCH-1:0][DW-1:0] hold_d, dout;
  logic ext_q, ext_rise, ctrl_we, sw_we, st_we;

  assign ctrl_we  = bus_we_i && (bus_addr_i == A_CTRL);
  assign sw_we    = bus_we_i && (bus_addr_i == A_SWTRIG);
  assign st_we    = bus_we_i && (bus_addr_i == A_STATUS);
  assign ext_rise = ext_trig_i & ~ext_q;

  dac_wr_decode u_dec (
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .hold_we_o (hold_we),
    .hold_d_o  (hold_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      ext_q <= ext_trig_i;
      if (ctrl_we)
        for (int c = 0; c < NCH; c++) cfg_q[c] <= ch_cfg_t'(bus_wdata_i[c*HALF +: CFG_W]);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_channel u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_i      (cfg_q[c]),
      .hold_we_i  (hold_we[c]),
      .hold_d_i   (hold_d[c]),
      .sw_set_i   (sw_we & bus_wdata_i[c]),
      .tim_i      (tim_trig_i),
      .ext_rise_i (ext_rise),
      .ur_clr_i   (st_we & bus_wdata_i[c]),
      .dout_o     (dout[c]),
      .sw_o       (sw[c]),
      .dma_req_o  (req[c]),
      .underrun_o (ur[c])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL:   for (int c = 0; c < NCH; c++) bus_rdata_o[c*HALF +: CFG_W] = cfg_q[c];
      A_SWTRIG: bus_rdata_o[NCH-1:0] = sw;
      A_STATUS: bus_rdata_o[NCH-1:0] = ur;
      A_DOUT1:  bus_rdata_o[DW-1:0]  = dout[0];
      A_DOUT2:  bus_rdata_o[DW-1:0]  = dout[1];
      default:  ;
    endcase
  end

  assign dac1_data_o = dout[0];
  assign dac2_data_o = dout[1];
  assign dma_req_o   = req;

  AST_ST_W0_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we && ur[0] && !bus_wdata_i[0] |=> ur[0]); // R11
  AST_CTRL_RB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> cfg_q[1] == ch_cfg_t'($past(bus_wdata_i[HALF +: CFG_W]))); // R8
endmodule

// File: tb/dac_trig_ctrl_bench.sv
`timescale 1ns/1ps
module dac_trig_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  tim = '0;
  logic        ext = 1'b0;
  logic [11:0] dac1, dac2;
  logic [1:0]  dma;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_trig_ctrl u_dac_trig_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .tim_trig_i(tim), .ext_trig_i(ext),
    .dac1_data_o(dac1), .dac2_data_o(dac2), .dma_req_o(dma));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic pulse_tim(input int i);
    @(negedge clk); tim[i] = 1'b1;
    @(negedge clk); tim = '0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] fx(input int f, input logic [15:0] d);
    if (f == 1) return d[15:4];
    if (f == 2) return {d[7:0], 4'h0};
    return d[11:0];
  endfunction

  function automatic logic [11:0] cur(input int ch);
    return ch == 0 ? dac1 : dac2;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [11:0] e1, e2, old;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    chk("R1 dac1", {20'h0, dac1}, 0);
    chk("R1 dac2", {20'h0, dac2}, 0);
    chk("R1 dma", {30'h0, dma}, 0);
    rd(8'h00, r); chk("R1 ctrl", r, 0);
    rd(8'h04, r); chk("R1 swtrig", r, 0);
    rd(8'h08, r); chk("R1 status", r, 0);

    // R8 control layout, both channels direct
    wr(8'h00, 32'h0001_0001);
    rd(8'h00, r); chk("R8 ctrl rb", r, 32'h0001_0001);
    wr(8'h00, 32'h003F_0023);
    rd(8'h00, r); chk("R8 ctrl rb halves", r, 32'h003F_0023);
    wr(8'h00, 32'h0001_0001);

    // R2 R4 single-channel format sweep
    for (int ch = 0; ch < 2; ch++)
      for (int f = 0; f < 3; f++)
        for (int k = 0; k < 8; k++) begin
          logic [15:0] d;
          d = 16'(k * 16'h1357 + 16'h0a5c + f * 16'h0101 + ch * 16'h3000);
          old = cur(ch);
          wr(8'(8'h10 + ch * 8'h10 + f * 4), {16'h0, d});
          chk("R4 not before second edge", {20'h0, cur(ch)}, {20'h0, old});
          wait_n(1);
          chk("R2 format", {20'h0, cur(ch)}, {20'h0, fx(f, d)});
        end
    rd(8'h40, r); chk("R12 dout1 rb", r, {20'h0, dac1});
    rd(8'h44, r); chk("R12 dout2 rb", r, {20'h0, dac2});

    // R3 dual aliases
    for (int f = 0; f < 3; f++)
      for (int k = 0; k < 8; k++) begin
        logic [31:0] d;
        d = k * 32'h0135_79bd + 32'h8a5c_3e71 + f * 32'h1111_0000;
        wr(8'(8'h30 + f * 4), d);
        wait_n(1);
        e1 = fx(f, d[15:0]);
        e2 = (f == 2) ? fx(2, {8'h0, d[15:8]}) : fx(f, d[31:16]);
        chk("R3 dual ch1", {20'h0, dac1}, {20'h0, e1});
        chk("R3 dual ch2", {20'h0, dac2}, {20'h0, e2});
      end

    // R5 R6 timer selection on channel 1
    for (int t = 0; t < 6; t++) begin
      logic [11:0] v;
      v = 12'(12'h100 + t * 12'h0a3);
      wr(8'h00, 32'h0001_0000 | (32'h3 | (t << 2)));
      old = dac1;
      wr(8'h10, {20'h0, v});
      wait_n(2);
      chk("R5 write held in trigger mode", {20'h0, dac1}, {20'h0, old});
      pulse_tim((t + 1) % 6);
      @(negedge clk); ext = 1'b1; @(negedge clk); ext = 1'b0;
      wait_n(2);
      chk("R6 unselected sources ignored", {20'h0, dac1}, {20'h0, old});
      pulse_tim(t);
      chk("R5 not at detect edge", {20'h0, dac1}, {20'h0, old});
      wait_n(1);
      chk("R6 timer selected", {20'h0, dac1}, {20'h0, v});
    end

    // R6 external rising edge on channel 2
    wr(8'h00, 32'h001B_0001);
    old = dac2;
    wr(8'h20, 32'h0000_0abc);
    @(negedge clk); ext = 1'b1;
    @(negedge clk);
    chk("R6 ext at detect edge", {20'h0, dac2}, {20'h0, old});
    wait_n(1);
    chk("R6 ext rise", {20'h0, dac2}, 32'h0abc);
    wr(8'h20, 32'h0000_0123);
    wait_n(3);
    chk("R6 ext level ignored", {20'h0, dac2}, 32'h0abc);
    ext = 1'b0;
    wait_n(3);
    chk("R6 ext fall ignored", {20'h0, dac2}, 32'h0abc);
    ext = 1'b1;
    wait_n(2);
    chk("R6 ext second rise", {20'h0, dac2}, 32'h0123);
    ext = 1'b0;

    // R7 software trigger on channel 1
    wr(8'h00, 32'h0001_001F);
    wr(8'h10, 32'h0000_0777);
    old = dac1;
    wr(8'h04, 32'h1);
    rd(8'h04, r); chk("R7 sw bit set", r, 32'h1);
    @(negedge clk);
    rd(8'h04, r); chk("R7 sw bit auto-clear", r, 32'h0);
    chk("R7 no transfer yet", {20'h0, dac1}, {20'h0, old});
    wait_n(1);
    chk("R7 sw transfer", {20'h0, dac1}, 32'h0777);

    // R9 disabled channel 2
    wr(8'h00, 32'h0000_0001);
    old = dac2;
    wr(8'h20, 32'h0000_0555);
    wait_n(3);
    chk("R9 disabled write", {20'h0, dac2}, {20'h0, old});
    wr(8'h00, 32'h0002_0001);
    pulse_tim(0);
    wait_n(2);
    chk("R9 disabled trigger", {20'h0, dac2}, {20'h0, old});

    // R10 R11 DMA request and underrun on channel 1
    wr(8'h10, 32'h0000_0999);
    wr(8'h00, 32'h0000_0023);
    chk("R10 idle request", {30'h0, dma}, 0);
    pulse_tim(0);
    chk("R10 request raised", {30'h0, dma}, 32'h1);
    wait_n(1);
    chk("R10 first transfer", {20'h0, dac1}, 32'h0999);
    wr(8'h10, 32'h0000_0111);
    chk("R10 request dropped", {30'h0, dma}, 0);
    pulse_tim(0);
    wait_n(1);
    chk("R10 second transfer", {20'h0, dac1}, 32'h0111);
    pulse_tim(0);
    rd(8'h08, r); chk("R11 underrun set", r, 32'h1);
    wait_n(2);
    chk("R11 no transfer on starve", {20'h0, dac1}, 32'h0111);
    chk("R11 request held", {30'h0, dma}, 32'h1);
    wr(8'h08, 32'h0);
    rd(8'h08, r); chk("R11 write 0 keeps", r, 32'h1);
    wr(8'h08, 32'h1);
    rd(8'h08, r); chk("R11 write 1 clears", r, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule